// File: doc/BRIEF.md
# Modem Control and Status Unit

This unit holds the modem control byte and the modem status byte of a byte-wide serial port. It samples four incoming handshake lines: clear-to-send, data-set-ready, carrier-detect and ring. Each line passes through a two-stage synchronizer and is then compared with the level last recorded. Any change raises a sticky change flag for that line. The ring line is the exception: its flag rises only when ring drops from high to low. A read of the status byte returns the current byte and clears all change flags.

The control byte drives four outgoing lines: request-to-send, terminal-ready and two general outputs. A fifth control bit selects loopback. In loopback the status byte shows the control outputs instead of the sampled lines. Request-to-send and terminal-ready are held low at the pins, and the recorded status and flags are frozen. A modem interrupt request goes high while an external enable is high and at least one change flag is set.

Registers are reached through a single-cycle read/write port with a one-bit register select. Select 0 is the control byte and select 1 is the status byte. Read data is combinational from the register state. The side effects of a read take effect at the clock edge on which `rdEn` is high.

Top module: `mdm_top`

## Requirements
- R1: After reset the control byte reads 0x08 and the status byte reads 0xB0. Only general output 2 is high at the pins.
- R2: A write to select 0 stores `wrData[4:0]`. A read of select 0 returns the stored bits with bits 7:5 as zero. Bit 4 is loopback, bit 3 is general output 2, bit 2 is general output 1, bit 1 is request-to-send and bit 0 is terminal-ready.
- R3: A change on an input line shows in the status byte after exactly three rising clock edges.
- R4: Status bits 7..4 hold carrier-detect, ring, data-set-ready and clear-to-send. Bits 3, 1 and 0 are change flags for carrier-detect, data-set-ready and clear-to-send. Each flag is set by a change in either direction and stays set until a clearing read.
- R5: Bit 2 is the ring flag. It is set only when the recorded ring level goes from 1 to 0. A rising ring does not set it.
- R6: Outside loopback, a read of select 1 returns the byte as it was before the clock edge. Bits 3:0 are then cleared at that edge.
- R7: A line change that lands on the same edge as a clearing read leaves its flag set after that read.
- R8: In loopback, reading select 1 returns general output 2 at bit 7, general output 1 at bit 6, terminal-ready at bit 5 and request-to-send at bit 4, with bits 3:0 zero. Such a read clears nothing.
- R9: While loopback is set, request-to-send and terminal-ready are low at the pins and the recorded status byte does not change. Once loopback is left, levels that differ from the recorded ones set their flags.
- R10: Outside loopback, the request-to-send and terminal-ready pins follow control bits 1 and 0. The two general output pins follow control bits 2 and 3 in every mode.
- R11: `modemIrq` is high exactly when `modemIntEn` is high and any of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects at the edge) |
| regAddr | input | 1 | 0 selects control, 1 selects status |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| modemIntEn | input | 1 | Enable for the modem interrupt request |
| ctsIn | input | 1 | Clear-to-send input line |
| dsrIn | input | 1 | Data-set-ready input line |
| dcdIn | input | 1 | Carrier-detect input line |
| riIn | input | 1 | Ring input line |
| rtsOut | output | 1 | Request-to-send output |
| dtrOut | output | 1 | Terminal-ready output |
| out1Out | output | 1 | General output 1 |
| out2Out | output | 1 | General output 2 |
| modemIrq | output | 1 | Modem interrupt request |

## Verification
The clearing read of the status byte and the setting of a change flag can fall on the same clock edge. The bench changes data-set-ready two edges before the edge on which it holds a status read. The synchronized change therefore reaches the comparison on exactly that read edge. The bench then expects the earlier ring flag to be gone and the new data-set-ready flag to be present. A free-running reference model also meets this collision many times during the random phase, where reads and line toggles are mixed.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int LINE_CNT = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RING = 2;
  localparam int IDX_DCD = 3;
  localparam int CTRL_BITS = 5;
  localparam int LOOP_BIT = 4;
  localparam int BYTE_W = 8;
  localparam logic [LINE_CNT-1:0] LINES_RESET = 4'b1011;
  localparam logic [CTRL_BITS-1:0] CTRL_RESET = 5'h08;

  typedef struct packed {
    logic clrDelta;
    logic loopMode;
    logic [LINE_CNT-1:0] loopLines;
  } mdmStrobe_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic clk,
  input  logic rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[g] <= RESET_VAL;
      else if (g == 0) stageQ[g] <= din;
      else stageQ[g] <= stageQ[(g == 0) ? 0 : g-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic regAddr,
  input  logic [CTRL_BITS-1:0] wrBits,
  output logic [CTRL_BITS-1:0] ctrlQ,
  output mdmStrobe_t strobe,
  output logic rtsOut,
  output logic dtrOut,
  output logic out1Out,
  output logic out2Out
);
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  logic loopOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= CTRL_RESET;
    else if (wrEn && regAddr == ADDR_CTRL) ctrlQ <= wrBits;
  end

  assign loopOn = ctrlQ[LOOP_BIT];

  always_comb begin
    strobe.loopMode = loopOn;
    strobe.clrDelta = rdEn && (regAddr == ADDR_STAT) && !loopOn;
    strobe.loopLines[IDX_DCD]  = ctrlQ[3];
    strobe.loopLines[IDX_RING] = ctrlQ[2];
    strobe.loopLines[IDX_DSR]  = ctrlQ[0];
    strobe.loopLines[IDX_CTS]  = ctrlQ[1];
  end

  assign rtsOut  = ctrlQ[1] && !loopOn;
  assign dtrOut  = ctrlQ[0] && !loopOn;
  assign out1Out = ctrlQ[2];
  assign out2Out = ctrlQ[3];
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic [LINE_CNT-1:0] syncLines,
  input  mdmStrobe_t strobe,
  input  logic modemIntEn,
  output logic [BYTE_W-1:0] statusByte,
  output logic modemIrq
);
  logic [LINE_CNT-1:0] linesQ;
  logic [LINE_CNT-1:0] deltaQ;
  logic [LINE_CNT-1:0] edgeSeen;
  logic [LINE_CNT-1:0] deltaNext;

  for (genvar i = 0; i < LINE_CNT; i++) begin : gLine
    if (i == IDX_RING) begin : gTrail
      assign edgeSeen[i] = linesQ[i] && !syncLines[i];
    end else begin : gAny
      assign edgeSeen[i] = linesQ[i] ^ syncLines[i];
    end
    assign deltaNext[i] = (deltaQ[i] && !strobe.clrDelta) ||
                          (edgeSeen[i] && !strobe.loopMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linesQ <= LINES_RESET;
      deltaQ <= '0;
    end else begin
      deltaQ <= deltaNext;
      if (!strobe.loopMode) linesQ <= syncLines;
    end
  end

  assign statusByte = {linesQ, deltaQ};
  assign modemIrq = modemIntEn && (|deltaQ);
endmodule

// File: rtl/mdm_top.sv
module mdm_top
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic modemIntEn,
  input  logic ctsIn,
  input  logic dsrIn,
  input  logic dcdIn,
  input  logic riIn,
  output logic rtsOut,
  output logic dtrOut,
  output logic out1Out,
  output logic out2Out,
  output logic modemIrq
);
  localparam int PAD_BITS = BYTE_W - CTRL_BITS;
  localparam int NIB = BYTE_W - LINE_CNT;

  logic [LINE_CNT-1:0] rawLines;
  logic [LINE_CNT-1:0] syncLines;
  logic [CTRL_BITS-1:0] ctrlQ;
  logic [BYTE_W-1:0] statusByte;
  mdmStrobe_t strobe;

  always_comb begin
    rawLines[IDX_CTS]  = ctsIn;
    rawLines[IDX_DSR]  = dsrIn;
    rawLines[IDX_RING] = riIn;
    rawLines[IDX_DCD]  = dcdIn;
  end

  mdm_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES), .RESET_VAL(LINES_RESET)) uSync (
    .clk(clk), .rstN(rstN), .din(rawLines), .dout(syncLines)
  );

  mdm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrBits(wrData[CTRL_BITS-1:0]), .ctrlQ(ctrlQ), .strobe(strobe),
    .rtsOut(rtsOut), .dtrOut(dtrOut), .out1Out(out1Out), .out2Out(out2Out)
  );

  mdm_status uStat (
    .clk(clk), .rstN(rstN), .syncLines(syncLines), .strobe(strobe),
    .modemIntEn(modemIntEn), .statusByte(statusByte), .modemIrq(modemIrq)
  );

  always_comb begin
    if (!regAddr) rdData = {{PAD_BITS{1'b0}}, ctrlQ};
    else if (strobe.loopMode) rdData = {strobe.loopLines, {NIB{1'b0}}};
    else rdData = statusByte;
  end
endmodule

// File: rtl/mdm_top_chk.sv
module mdm_top_chk (
  input logic clk,
  input logic rstN,
  input logic rdEn,
  input logic regAddr,
  input logic [7:0] rdData,
  input logic modemIntEn,
  input logic modemIrq,
  input logic rtsOut,
  input logic dtrOut,
  input logic [4:0] ctrlQ,
  input logic [3:0] syncLines,
  input logic [7:0] statusByte
);
  // R2
  ctrl_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> rdData[7:5] == 3'b000);

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && regAddr && !ctrlQ[4]) |=>
      ((statusByte[3:0] & $past(statusByte[3:0])) == $past(statusByte[3:0])));

  // R5
  ring_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statusByte[2] && !(statusByte[6] && !syncLines[2])) |=> !statusByte[2]);

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regAddr && !ctrlQ[4] && syncLines == statusByte[7:4]) |=>
      statusByte[3:0] == 4'h0);

  // R8
  loop_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr && ctrlQ[4]) |->
      rdData == {ctrlQ[3], ctrlQ[2], ctrlQ[0], ctrlQ[1], 4'h0});

  // R9
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[4] |-> (!rtsOut && !dtrOut));

  // R9
  loop_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[4] |=> $stable(statusByte));

  // R11
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    modemIrq == (modemIntEn && (statusByte[3:0] != 4'h0)));
endmodule

bind mdm_top mdm_top_chk uChk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .regAddr(regAddr), .rdData(rdData),
  .modemIntEn(modemIntEn), .modemIrq(modemIrq), .rtsOut(rtsOut),
  .dtrOut(dtrOut), .ctrlQ(ctrlQ), .syncLines(syncLines),
  .statusByte(statusByte)
);

// File: tb/mdm_top_test.sv
`timescale 1ns/1ps
module mdm_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, regAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic modemIntEn = 1'b0;
  logic ctsIn = 1'b1, dsrIn = 1'b1, dcdIn = 1'b1, riIn = 1'b0;
  logic rtsOut, dtrOut, out1Out, out2Out, modemIrq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mdm_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .modemIntEn(modemIntEn),
    .ctsIn(ctsIn), .dsrIn(dsrIn), .dcdIn(dcdIn), .riIn(riIn),
    .rtsOut(rtsOut), .dtrOut(dtrOut), .out1Out(out1Out), .out2Out(out2Out),
    .modemIrq(modemIrq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // behavioural reference model
  logic [4:0] mCtl = 5'h08;
  logic [3:0] mLvl = 4'hB;
  logic [3:0] mFlg = 4'h0;
  logic [3:0] pipeQ[$] = '{4'hB, 4'hB};

  always @(posedge clk) begin
    logic [3:0] seen;
    logic [3:0] nf;
    if (!rstN) begin
      mCtl <= 5'h08; mLvl <= 4'hB; mFlg <= 4'h0;
      pipeQ = '{4'hB, 4'hB};
    end else begin
      seen = pipeQ.pop_front();
      pipeQ.push_back({dcdIn, riIn, dsrIn, ctsIn});
      nf = (rdEn && regAddr && !mCtl[4]) ? 4'h0 : mFlg;
      if (!mCtl[4]) begin
        nf[0] = nf[0] | (mLvl[0] ^ seen[0]);
        nf[1] = nf[1] | (mLvl[1] ^ seen[1]);
        nf[3] = nf[3] | (mLvl[3] ^ seen[3]);
        nf[2] = nf[2] | (mLvl[2] & ~seen[2]);
        mLvl <= seen;
      end
      mFlg <= nf;
      if (wrEn && !regAddr) mCtl <= wrData[4:0];
    end
  end

  always @(negedge clk) begin
    logic [7:0] expRd;
    if (rstN) begin
      if (!regAddr) begin
        chk("R2 control read", rdData, {3'b000, mCtl});
      end else if (mCtl[4]) begin
        chk("R8 loopback status read", rdData,
            {mCtl[3], mCtl[2], mCtl[0], mCtl[1], 4'h0});
      end else begin
        expRd = {mLvl, mFlg};
        chk("R4 status read", rdData, expRd);
      end
      chk("R11 irq", {7'b0, modemIrq}, {7'b0, modemIntEn && (mFlg != 4'h0)});
      chk("R9/R10 pins", {4'b0, rtsOut, dtrOut, out1Out, out2Out},
          {4'b0, mCtl[1] & ~mCtl[4], mCtl[0] & ~mCtl[4], mCtl[2], mCtl[3]});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset values
    regAddr = 1'b0; tick();
    chk("R1 control reset", rdData, 8'h08);
    chk("R1 pins reset", {4'b0, rtsOut, dtrOut, out1Out, out2Out}, 8'h01);
    regAddr = 1'b1; tick();
    chk("R1 status reset", rdData, 8'hB0);

    // R3 latency, R4 flag on clear-to-send fall
    ctsIn = 1'b0;
    tick(); tick();
    chk("R3 not yet visible", rdData, 8'hB0);
    tick();
    chk("R3 visible after three edges", rdData, 8'hA1);
    modemIntEn = 1'b1; tick();
    chk("R11 irq raised", {7'b0, modemIrq}, 8'h01);

    // R6 clearing read
    rdEn = 1'b1; tick(); rdEn = 1'b0;
    chk("R6 flags cleared", rdData, 8'hA0);
    chk("R11 irq dropped", {7'b0, modemIrq}, 8'h00);

    // R5 ring edges
    riIn = 1'b1; repeat (3) tick();
    chk("R5 ring rise sets no flag", rdData, 8'hE0);
    riIn = 1'b0; repeat (3) tick();
    chk("R5 ring fall sets flag", rdData, 8'hA4);

    // R7 read and new change on the same edge
    dsrIn = 1'b0; tick(); tick();
    chk("R7 before collision", rdData, 8'hA4);
    rdEn = 1'b1; tick(); rdEn = 1'b0;
    chk("R7 new flag survives read", rdData, 8'h82);
    rdEn = 1'b1; tick(); rdEn = 1'b0;
    chk("R6 second clear", rdData, 8'h80);

    // R2 write masking, R8/R9/R10 loopback
    regAddr = 1'b0; wrEn = 1'b1; wrData = 8'hFF; tick(); wrEn = 1'b0;
    chk("R2 upper bits dropped", rdData, 8'h1F);
    chk("R9 pins quiet in loopback", {4'b0, rtsOut, dtrOut, out1Out, out2Out}, 8'h03);
    regAddr = 1'b1; tick();
    chk("R8 loop map all set", rdData, 8'hF0);
    ctsIn = 1'b1; repeat (4) tick();
    rdEn = 1'b1; tick(); rdEn = 1'b0;
    regAddr = 1'b0; wrEn = 1'b1; wrData = 8'h15; tick(); wrEn = 1'b0;
    regAddr = 1'b1; tick();
    chk("R8 loop map partial", rdData, 8'h60);
    regAddr = 1'b0; wrEn = 1'b1; wrData = 8'h03; tick(); wrEn = 1'b0;
    chk("R10 request and ready driven", {4'b0, rtsOut, dtrOut, out1Out, out2Out}, 8'h0C);
    regAddr = 1'b1; tick();
    chk("R9 change during loop flagged on exit", rdData, 8'h91);

    // mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      wrEn = ($urandom % 8) == 0;
      rdEn = ($urandom % 3) == 0;
      regAddr = $urandom % 2;
      wrData = 8'($urandom);
      if (($urandom % 6) == 0) ctsIn = ~ctsIn;
      if (($urandom % 6) == 0) dsrIn = ~dsrIn;
      if (($urandom % 6) == 0) dcdIn = ~dcdIn;
      if (($urandom % 5) == 0) riIn = ~riIn;
      if (($urandom % 16) == 0) modemIntEn = ~modemIntEn;
      tick();
    end
    wrEn = 1'b0; rdEn = 1'b0;
    repeat (4) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule